// File: doc/BRIEF.md
# Bus Cycle Responder with Reply Timeout

This block sits on a processor bus that carries the address and data on one set of shared lines, marked by a cycle-start strobe and two direction strobes. When a bus cycle opens, the block captures the address from the shared lines and decodes which local device region it falls in. It then returns a registered acknowledge to the processor once the selected device pulses its ready strobe while a transfer strobe is active. The acknowledge is the only thing that lets the processor move past a transfer.

A processor on this bus waits forever for the acknowledge. The block therefore counts clocks from the start of every cycle. If no selected device answers within a programmable limit, it acknowledges anyway and records a sticky bus error together with the failing address. For byte writes it also presents the outgoing data with the upper byte cleared, since the processor leaves that byte undefined.

Device regions, block size, bus width, device count and the reset timeout limit are all parameters. An optional register stage on the ready strobes is chosen at elaboration.

Top module: `bus_reply_ctrl`

## Requirements
- R1: On the first clock edge where `sync_i` is sampled high after being low, `addr_o` takes the value of `bus_ad_i` and holds it while the shared lines later carry data.
- R2: With defaults, device i (base 0x0040, 0x1000, 0x2000, 0x3000 for i = 0..3) is selected when address bits [15:4] equal those of its base; `dev_sel_o` bit i is then high from the capture edge while `sync_i` stays high.
- R3: When the selected device's ready bit is sampled high while `din_i` or `dout_i` is high, `reply_o` is high after that same edge and stays high, without further strobes, while `din_i` or `dout_i` remains high.
- R4: A ready strobe from a device that is not selected has no effect on `reply_o`.
- R5: `reply_o` is low after the first clock edge at which both `din_i` and `dout_i` are sampled low.
- R6: If no selected ready arrives, counting the capture edge as edge 0, `reply_o` rises after edge L, where L is the timeout limit (64 after reset).
- R7: A timeout sets `bus_err_o` and loads `err_addr_o` with the captured address. Both hold against later timeouts until cleared.
- R8: `err_clr_i` sampled high clears `bus_err_o` unless a timeout occurs on the same edge.
- R9: `cfg_we_i` sampled high loads `cfg_limit_i` as the new timeout limit.
- R10: The timeout count restarts with each cycle. Clocks spent in an earlier cycle never shorten the next one.
- R11: While `dout_i` and `wtbt_i` are both high, `wdata_o[15:8]` is zero and `wdata_o[7:0]` equals `bus_ad_i[7:0]`; otherwise `wdata_o` equals `bus_ad_i`.
- R12: `dev_sel_o` is all zero after any edge where `sync_i` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-phase clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad_i | input | 16 | Shared address/data lines |
| sync_i | input | 1 | Cycle-start strobe; address valid at its rise |
| din_i | input | 1 | Transfer toward the processor |
| dout_i | input | 1 | Transfer from the processor |
| wtbt_i | input | 1 | Byte-write marker during output |
| dev_ready_i | input | 4 | Per-device ready strobes |
| err_clr_i | input | 1 | Clears the sticky bus error |
| cfg_we_i | input | 1 | Loads a new timeout limit |
| cfg_limit_i | input | 8 | New timeout limit in clocks |
| reply_o | output | 1 | Registered acknowledge to the processor |
| dev_sel_o | output | 4 | One-hot selected device |
| addr_o | output | 16 | Captured cycle address |
| wdata_o | output | 16 | Outgoing data with upper byte cleared on byte writes |
| bus_err_o | output | 1 | Sticky timeout flag |
| err_addr_o | output | 16 | Address of the first failing cycle |

## Verification
On every cycle the assertions check the following: the address capture at the cycle start, the one-hot device select and its clearing when the cycle ends, the acknowledge falling after the transfer strobes drop, the byte-write zeroing, the count clearing between cycles, and the sticky error holding its address. Only the bench scenarios can show the exact timeout edge for both the reset limit and a reprogrammed one. The same holds for the foreign-ready strobe leaving the cycle unacknowledged until the timeout, and for the first failing address surviving a second timeout.

// File: rtl/bus_resp_pkg.sv
package bus_resp_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      XF_NONE = 2'd0,
      XF_IN   = 2'd1,
      XF_OUT  = 2'd2,
      XF_BYTE = 2'd3
   } xfer_kind_e;

   function automatic xfer_kind_e classify(input logic din, input logic dout, input logic bytew);
      if (dout && bytew) return XF_BYTE;
      if (dout)          return XF_OUT;
      if (din)           return XF_IN;
      return XF_NONE;
   endfunction
endpackage

// File: rtl/bus_addr_decode.sv
module bus_addr_decode #(
   parameter int unsigned DW       = 16,
   parameter int unsigned NDEV     = 4,
   parameter int unsigned BLK_BITS = 4,
   parameter logic [NDEV-1:0][DW-1:0] DEV_BASE = '0
) (
   input  logic [DW-1:0]   addr_i,
   output logic [NDEV-1:0] match_o
);
   localparam int unsigned CMP_W = DW - BLK_BITS;

   if (BLK_BITS >= DW) begin : g_bad_blk
      $error("BLK_BITS must be below DW");
   end

   for (genvar d = 0; d < NDEV; d++) begin : g_dev
      for (genvar e = d + 1; e < NDEV; e++) begin : g_uniq
         if (DEV_BASE[d][DW-1:BLK_BITS] == DEV_BASE[e][DW-1:BLK_BITS]) begin : g_overlap
            $error("device regions overlap");
         end
      end
      logic [CMP_W-1:0] tag;
      assign tag        = DEV_BASE[d][DW-1:BLK_BITS];
      assign match_o[d] = (addr_i[DW-1:BLK_BITS] == tag);
   end
endmodule

// File: rtl/bus_timeout_ctr.sv
module bus_timeout_ctr #(
   parameter int unsigned LIMW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_i,
   input  logic [LIMW-1:0] limit_i,
   output logic            expired_o
);
   logic [LIMW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_i)         cnt_q <= '0;
      else if (cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q >= limit_i);

   // R10
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/bus_err_status.sv
module bus_err_status #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic [DW-1:0] addr_i,
   input  logic          clr_i,
   output logic          err_o,
   output logic [DW-1:0] addr_o
);
   logic          err_q;
   logic [DW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         if (set_i)      err_q <= 1'b1;
         else if (clr_i) err_q <= 1'b0;
         if (set_i && !err_q) addr_q <= addr_i;
      end
   end

   assign err_o  = err_q;
   assign addr_o = addr_q;

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr_i) |=> (err_q && $stable(addr_q)));
endmodule

// File: rtl/bus_reply_ctrl.sv
module bus_reply_ctrl #(
   parameter int unsigned DW         = 16,
   parameter int unsigned NDEV       = 4,
   parameter int unsigned BLK_BITS   = 4,
   parameter int unsigned LIMW       = 8,
   parameter int unsigned TO_DEFAULT = 64,
   parameter bit          READY_REG  = 1'b0,
   parameter logic [NDEV-1:0][DW-1:0] DEV_BASE =
      {16'h3000, 16'h2000, 16'h1000, 16'h0040}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   bus_ad_i,
   input  logic            sync_i,
   input  logic            din_i,
   input  logic            dout_i,
   input  logic            wtbt_i,
   input  logic [NDEV-1:0] dev_ready_i,
   input  logic            err_clr_i,
   input  logic            cfg_we_i,
   input  logic [LIMW-1:0] cfg_limit_i,
   output logic            reply_o,
   output logic [NDEV-1:0] dev_sel_o,
   output logic [DW-1:0]   addr_o,
   output logic [DW-1:0]   wdata_o,
   output logic            bus_err_o,
   output logic [DW-1:0]   err_addr_o
);
   import bus_resp_pkg::*;

   localparam int unsigned HI_W = DW - BYTE_W;
   localparam logic [LIMW-1:0] LIM_RST = LIMW'(TO_DEFAULT);

   if (NDEV < 1)                   begin : g_chk_ndev $error("NDEV must be at least 1"); end
   if (DW <= BYTE_W)               begin : g_chk_dw   $error("DW must exceed a byte"); end
   if (TO_DEFAULT < 1)             begin : g_chk_to0  $error("TO_DEFAULT must be positive"); end
   if (TO_DEFAULT >= (1 << LIMW))  begin : g_chk_to1  $error("TO_DEFAULT exceeds LIMW"); end

   // cycle start and address capture
   logic            sync_q;
   logic            sync_rise;
   logic [DW-1:0]   addr_q;
   logic [NDEV-1:0] match;
   logic [NDEV-1:0] sel_q;

   assign sync_rise = sync_i && !sync_q;

   bus_addr_decode #(
      .DW(DW), .NDEV(NDEV), .BLK_BITS(BLK_BITS), .DEV_BASE(DEV_BASE)
   ) u_dec (
      .addr_i (bus_ad_i),
      .match_o(match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         addr_q <= '0;
         sel_q  <= '0;
      end else begin
         sync_q <= sync_i;
         if (sync_rise) begin
            addr_q <= bus_ad_i;
            sel_q  <= match;
         end else if (!sync_i) begin
            sel_q  <= '0;
         end
      end
   end

   // ready strobe path: direct or one register stage
   logic [NDEV-1:0] ready_s;
   if (READY_REG) begin : g_rdy_reg
      logic [NDEV-1:0] rdy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdy_q <= '0;
         else        rdy_q <= dev_ready_i;
      end
      assign ready_s = rdy_q;
   end else begin : g_rdy_dir
      assign ready_s = dev_ready_i;
   end

   // timeout limit register
   logic [LIMW-1:0] limit_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        limit_q <= LIM_RST;
      else if (cfg_we_i) limit_q <= cfg_limit_i;
   end

   logic expired;
   bus_timeout_ctr #(.LIMW(LIMW)) u_to (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (sync_i),
      .limit_i  (limit_q),
      .expired_o(expired)
   );

   // reply generation
   logic xfer;
   logic ready_hit;
   logic to_hit;
   logic reply_q;

   assign xfer      = din_i || dout_i;
   assign ready_hit = sync_q && sync_i && |(sel_q & ready_s);
   assign to_hit    = sync_q && sync_i && xfer && expired && !reply_q && !ready_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reply_q <= 1'b0;
      else        reply_q <= xfer && (reply_q || ready_hit || to_hit);
   end

   bus_err_status #(.DW(DW)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (to_hit),
      .addr_i(addr_q),
      .clr_i (err_clr_i),
      .err_o (bus_err_o),
      .addr_o(err_addr_o)
   );

   // outgoing data with byte-write upper clearing
   xfer_kind_e kind;
   assign kind = classify(din_i, dout_i, wtbt_i);

   always_comb begin
      wdata_o = bus_ad_i;
      if (kind == XF_BYTE) wdata_o[DW-1:BYTE_W] = '0;
   end

   assign reply_o   = reply_q;
   assign dev_sel_o = sel_q;
   assign addr_o    = addr_q;

   // R1
   addr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && !sync_q) |=> (addr_o == $past(bus_ad_i)));
   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_sel_o));
   // R12
   sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> (dev_sel_o == '0));
   // R5
   reply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!din_i && !dout_i) |=> !reply_o);
   // R11
   byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_i && wtbt_i) |-> (wdata_o[DW-1:BYTE_W] == '0 && wdata_o[BYTE_W-1:0] == bus_ad_i[BYTE_W-1:0]));
   // R7
   err_on_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_err_o) |-> $rose(reply_o));
endmodule

// File: tb/bus_reply_ctrl_bench.sv
module bus_reply_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_ad = '0;
   logic        sync = 0, din = 0, dout = 0, wtbt = 0;
   logic [3:0]  rdy = '0;
   logic        eclr = 0, cwe = 0;
   logic [7:0]  clim = '0;
   logic        reply, berr;
   logic [3:0]  sel;
   logic [15:0] addr, wdata, eaddr;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bus_reply_ctrl u_bus_reply_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_ad_i(bus_ad), .sync_i(sync), .din_i(din),
      .dout_i(dout), .wtbt_i(wtbt), .dev_ready_i(rdy), .err_clr_i(eclr),
      .cfg_we_i(cwe), .cfg_limit_i(clim), .reply_o(reply), .dev_sel_o(sel),
      .addr_o(addr), .wdata_o(wdata), .bus_err_o(berr), .err_addr_o(eaddr));

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic open_cycle(input logic [15:0] a);
      bus_ad = a;
      sync = 1;
      step();
   endtask

   task automatic close_cycle();
      din = 0; dout = 0; wtbt = 0;
      step();
      sync = 0;
      step();
   endtask

   task automatic t_reset();
      check("R5 reset reply", reply, 0);
      check("R7 reset err", berr, 0);
      check("R12 reset sel", sel, 0);
   endtask

   task automatic t_read();
      open_cycle(16'h1004);
      check("R1 addr", addr, 16'h1004);
      check("R2 sel dev1", sel, 4'b0010);
      bus_ad = 16'hBEEF;
      din = 1;
      step(2);
      check("R3 no reply yet", reply, 0);
      check("R1 addr held", addr, 16'h1004);
      rdy = 4'b0010;
      step();
      check("R3 reply", reply, 1);
      rdy = 0;
      step(2);
      check("R3 reply held", reply, 1);
      din = 0;
      step();
      check("R5 reply drop", reply, 0);
      sync = 0;
      step();
      check("R12 sel clear", sel, 0);
   endtask

   task automatic t_write();
      open_cycle(16'h004A);
      check("R2 sel dev0", sel, 4'b0001);
      bus_ad = 16'hA55A;
      dout = 1;
      #0.5;
      check("R11 word data", wdata, 16'hA55A);
      wtbt = 1;
      #0.5;
      check("R11 byte data", wdata, 16'h005A);
      rdy = 4'b0001;
      step();
      check("R3 write reply", reply, 1);
      rdy = 0;
      close_cycle();
      check("R5 write drop", reply, 0);
   endtask

   task automatic t_foreign();
      open_cycle(16'h2010);
      check("R2 sel none", sel, 0);
      open_cycle(16'h2010);
      din = 1;
      close_cycle();
      open_cycle(16'h3008);
      din = 1;
      rdy = 4'b0111;
      step(3);
      check("R4 foreign ready", reply, 0);
      rdy = 0;
      close_cycle();
   endtask

   task automatic t_timeout(input int lim, input logic [15:0] a, input string tag);
      open_cycle(a);
      din = 1;
      step(lim - 1);
      check({tag, " before limit"}, reply, 0);
      step();
      check({tag, " at limit"}, reply, 1);
      close_cycle();
   endtask

   task automatic t_errs();
      t_timeout(64, 16'h5000, "R6");
      check("R7 err set", berr, 1);
      check("R7 err addr", eaddr, 16'h5000);
      t_timeout(64, 16'h6000, "R6 second");
      check("R7 err addr kept", eaddr, 16'h5000);
      eclr = 1;
      step();
      eclr = 0;
      check("R8 err cleared", berr, 0);
   endtask

   task automatic t_limit();
      clim = 8'd10;
      cwe = 1;
      step();
      cwe = 0;
      t_timeout(10, 16'h7000, "R9");
      check("R9 err addr", eaddr, 16'h7000);
      open_cycle(16'h7100);
      step(5);
      sync = 0;
      step();
      t_timeout(10, 16'h7200, "R10");
   endtask

   initial begin
      step(2);
      rst_n = 1;
      step();
      t_reset();
      t_read();
      t_write();
      t_foreign();
      t_errs();
      t_limit();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule